// File: doc/BRIEF.md
# Grouped TDM Serial Transmit Link

The block sends byte-wide channel data from several links onto 2.048 Mb/s serial streams. Each 125 us frame is 512 clock cycles of the 4.096 MHz bit clock. A frame holds 32 time slots of eight bits, and each bit cell lasts two clocks. An active-low frame sync, one clock long, marks each frame boundary. The block has one slot timer shared by all links, so every link stays locked to the same frame.

Each link has a 32-bit slot map. A link requests a byte one bit cell before each slot it owns. It shifts that byte out MSB first and drives zero in every slot it does not own. Because unowned slots are zero, links can be OR-combined in pairs or in groups of four, so that fractional-rate sources share one stream. A grouping stage performs this merge. The same stage flags any group whose slot maps overlap.

Top module: `tdm_tx_group`

## Requirements
- R1: While `rst` is high, `ser_out`, `byte_req`, `underrun` and `clash` are all zero on the clock edge after it is sampled.
- R2: Until `fsync_n` has been sampled low for the first time, `ser_out` stays 0 and no `byte_req` is issued.
- R3: Call the edge that samples `fsync_n` low edge 0. Take single mode (`grp_mode`=0), a mapped slot s, and bit j counted from the MSB (j=0 is bit 7). Stream k then shows bit 7-j of link k's byte for slot s in the two cycles after edges 2+16s+2j and 3+16s+2j. A frame lasts 512 cycles.
- R4: In a slot s whose map bit `slot_map[32k+s]` is 0, link k contributes logic 0 for all eight bit cells.
- R5: For a mapped slot s, `byte_req[k]` is a one-cycle pulse in the cycle after the edge where the frame count becomes 16s-2 (mod 512). A byte on `din[8k+:8]` is taken on any edge where `din_vld[k]` is high. It is held until the next mapped slot of that link starts, including a byte supplied before the first sync, which serves slot 0.
- R6: If no byte is held when a mapped slot starts, the link sends 0xFF in that slot and sets `underrun[k]`. The flag stays set until reset.
- R7: With `grp_mode`=1, stream 2j carries the bitwise OR of links 2j and 2j+1, and stream 2j+1 is 0.
- R8: With `grp_mode`=2 or 3, stream 4q carries the OR of links 4q to 4q+3, and the other three streams of the quad are 0. With `grp_mode`=0, stream k carries link k alone.
- R9: `clash[k]` is high one cycle after the maps and mode show that stream k leads a group (a pair or a quad) in which two links share a set map bit. It is 0 for non-leading streams and always 0 in single mode.
- R10: An `fsync_n` low at any point restarts the frame at slot 0, with the timing of R3 counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twice the serial data rate |
| rst | input | 1 | Synchronous active-high reset |
| fsync_n | input | 1 | Active-low frame sync, one clock wide |
| grp_mode | input | 2 | 0 single, 1 pairs, 2 or 3 quads |
| slot_map | input | NUM_LINKS*SLOTS | Slot ownership, link k in bits [SLOTS*k +: SLOTS] |
| din | input | NUM_LINKS*BYTE_W | Byte lanes, link k in bits [BYTE_W*k +: BYTE_W] |
| din_vld | input | NUM_LINKS | Byte on the lane is valid this cycle |
| byte_req | output | NUM_LINKS | One-cycle request for the next slot byte |
| underrun | output | NUM_LINKS | Sticky: a mapped slot went out as idle |
| ser_out | output | NUM_LINKS | Serial streams after grouping |
| clash | output | NUM_LINKS | Overlapping slot maps in the group led by this stream |

## Verification
The bench builds the block with its defaults: four links, 32 slots and eight-bit bytes. That is exactly one quad. This single quad reaches single, pair and quad grouping, and both pairs in pair mode. It covers overlap detection on a pair leader and on the quad leader, a byte that is preloaded before the first sync, a starved link in the middle of a group, and a sync that arrives early in the middle of a frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    GRP_SINGLE = 2'd0,
    GRP_PAIR   = 2'd1,
    GRP_QUAD   = 2'd2,
    GRP_QUAD_B = 2'd3
  } grp_mode_e;

  localparam int LINKS_PER_QUAD = 4;
  localparam int CLK_PER_BIT    = 2;

  function automatic logic maps_meet(input logic [63:0] a, input logic [63:0] b);
    return |(a & b);
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOTS  = 32,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fsync_n,
  output logic                        act,
  output logic [$clog2(SLOTS)-1:0]    nxt_slot,
  output logic [$clog2(BYTE_W):0]     nxt_sub,
  output logic [$clog2(BYTE_W)-1:0]   bit_idx,
  output logic                        sync_seen
);
  localparam int SUB_W  = $clog2(BYTE_W) + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = SLOT_W + SUB_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  // frame sync forces the count to the frame start, otherwise it wraps freely
  assign cnt_nxt  = fsync_n ? (cnt_q + CNT_W'(1)) : '0;
  assign act      = sync_seen | ~fsync_n;
  assign nxt_slot = cnt_nxt[CNT_W-1:SUB_W];
  assign nxt_sub  = cnt_nxt[SUB_W-1:0];
  assign bit_idx  = cnt_q[SUB_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sync_seen <= 1'b0;
    end else begin
      if (act) cnt_q <= cnt_nxt;
      if (!fsync_n) sync_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_link_tx.sv
module tdm_link_tx #(
  parameter int SLOTS  = 32,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        act,
  input  logic [$clog2(SLOTS)-1:0]    nxt_slot,
  input  logic [$clog2(BYTE_W):0]     nxt_sub,
  input  logic [$clog2(BYTE_W)-1:0]   bit_idx,
  input  logic [SLOTS-1:0]            slot_map,
  input  logic [BYTE_W-1:0]           din,
  input  logic                        din_vld,
  output logic                        byte_req,
  output logic                        bit_out,
  output logic                        underrun
);
  localparam int SUB_W  = $clog2(BYTE_W) + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [SUB_W-1:0] REQ_PT = SUB_W'(2 * BYTE_W - 2);

  logic [BYTE_W-1:0] hold_q;
  logic              have_q;
  logic [BYTE_W-1:0] cur_q;
  logic [SLOT_W-1:0] ahead_slot;
  logic              req_due;
  logic              load_due;
  logic              load_own;
  logic [BIT_W-1:0]  sel;

  assign ahead_slot = nxt_slot + SLOT_W'(1);
  assign req_due    = act && (nxt_sub == REQ_PT) && slot_map[ahead_slot];
  assign load_due   = act && (nxt_sub == '0);
  assign load_own   = load_due && slot_map[nxt_slot];
  assign sel        = BIT_W'(BYTE_W - 1) - bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      have_q   <= 1'b0;
      cur_q    <= '0;
      byte_req <= 1'b0;
      bit_out  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      byte_req <= req_due;
      bit_out  <= cur_q[sel];
      if (load_own) begin
        have_q <= 1'b0;
        if (din_vld)     cur_q <= din;
        else if (have_q) cur_q <= hold_q;
        else begin
          cur_q    <= '1;
          underrun <= 1'b1;
        end
      end else begin
        if (load_due) cur_q <= '0;
        if (din_vld) begin
          hold_q <= din;
          have_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_or_stage.sv
module tdm_or_stage
  import tdm_tx_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int SLOTS     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 grp_mode,
  input  logic [NUM_LINKS-1:0]       link_bits,
  input  logic [NUM_LINKS*SLOTS-1:0] slot_map,
  output logic [NUM_LINKS-1:0]       ser_out,
  output logic [NUM_LINKS-1:0]       clash
);
  localparam int QUADS = NUM_LINKS / LINKS_PER_QUAD;

  grp_mode_e mode;
  assign mode = grp_mode_e'(grp_mode);

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    logic [3:0]       b;
    logic [63:0]      m [4];
    logic [3:0]       o_pair, o_quad, c_pair, c_quad;
    logic [3:0]       out_q, clash_q;

    assign b = link_bits[LINKS_PER_QUAD*q +: LINKS_PER_QUAD];
    for (genvar l = 0; l < 4; l++) begin : g_map
      assign m[l] = 64'(slot_map[SLOTS*(LINKS_PER_QUAD*q+l) +: SLOTS]);
    end

    always_comb begin
      o_pair = {1'b0, b[3] | b[2], 1'b0, b[1] | b[0]};
      o_quad = {3'b000, |b};
      c_pair = {1'b0, maps_meet(m[2], m[3]), 1'b0, maps_meet(m[0], m[1])};
      c_quad = {3'b000,
                maps_meet(m[0], m[1]) | maps_meet(m[0], m[2]) |
                maps_meet(m[0], m[3]) | maps_meet(m[1], m[2]) |
                maps_meet(m[1], m[3]) | maps_meet(m[2], m[3])};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q   <= '0;
        clash_q <= '0;
      end else begin
        case (mode)
          GRP_SINGLE: begin
            out_q   <= b;
            clash_q <= '0;
          end
          GRP_PAIR: begin
            out_q   <= o_pair;
            clash_q <= c_pair;
          end
          default: begin
            out_q   <= o_quad;
            clash_q <= c_quad;
          end
        endcase
      end
    end

    assign ser_out[LINKS_PER_QUAD*q +: LINKS_PER_QUAD] = out_q;
    assign clash[LINKS_PER_QUAD*q +: LINKS_PER_QUAD]   = clash_q;
  end
endmodule

// File: rtl/tdm_tx_group.sv
module tdm_tx_group #(
  parameter int NUM_LINKS = 4,
  parameter int SLOTS     = 32,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fsync_n,
  input  logic [1:0]                  grp_mode,
  input  logic [NUM_LINKS*SLOTS-1:0]  slot_map,
  input  logic [NUM_LINKS*BYTE_W-1:0] din,
  input  logic [NUM_LINKS-1:0]        din_vld,
  output logic [NUM_LINKS-1:0]        byte_req,
  output logic [NUM_LINKS-1:0]        underrun,
  output logic [NUM_LINKS-1:0]        ser_out,
  output logic [NUM_LINKS-1:0]        clash
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int SUB_W  = BIT_W + 1;

  logic                 act;
  logic [SLOT_W-1:0]    nxt_slot;
  logic [SUB_W-1:0]     nxt_sub;
  logic [BIT_W-1:0]     bit_idx;
  logic                 sync_seen;
  logic [NUM_LINKS-1:0] link_bits;

  tdm_slot_timer #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .fsync_n  (fsync_n),
    .act      (act),
    .nxt_slot (nxt_slot),
    .nxt_sub  (nxt_sub),
    .bit_idx  (bit_idx),
    .sync_seen(sync_seen)
  );

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_link
    tdm_link_tx #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_link (
      .clk     (clk),
      .rst     (rst),
      .act     (act),
      .nxt_slot(nxt_slot),
      .nxt_sub (nxt_sub),
      .bit_idx (bit_idx),
      .slot_map(slot_map[SLOTS*k +: SLOTS]),
      .din     (din[BYTE_W*k +: BYTE_W]),
      .din_vld (din_vld[k]),
      .byte_req(byte_req[k]),
      .bit_out (link_bits[k]),
      .underrun(underrun[k])
    );
  end

  tdm_or_stage #(.NUM_LINKS(NUM_LINKS), .SLOTS(SLOTS)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .grp_mode (grp_mode),
    .link_bits(link_bits),
    .slot_map (slot_map),
    .ser_out  (ser_out),
    .clash    (clash)
  );
endmodule

// File: rtl/tdm_tx_group_chk.sv
module tdm_tx_group_chk #(
  parameter int NUM_LINKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fsync_n,
  input logic                 sync_seen,
  input logic [1:0]           grp_mode,
  input logic [NUM_LINKS-1:0] byte_req,
  input logic [NUM_LINKS-1:0] underrun,
  input logic [NUM_LINKS-1:0] ser_out,
  input logic [NUM_LINKS-1:0] clash
);
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      a_r1_reset_state: assert (ser_out == '0 && byte_req == '0 &&
                                underrun == '0 && clash == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  a_r2_no_req_unsynced: assert property (@(posedge clk) disable iff (rst)
    (!sync_seen && fsync_n) |=> (byte_req == '0))
    else $error("R2 request before first sync");

  a_r9_single_no_clash: assert property (@(posedge clk) disable iff (rst)
    ($past(grp_mode) == 2'd0) |-> (clash == '0))
    else $error("R9 clash in single mode");

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_lk
    a_r5_req_pulse: assert property (@(posedge clk) disable iff (rst)
      byte_req[k] |=> !byte_req[k])
      else $error("R5 request wider than one cycle");

    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
      underrun[k] |=> underrun[k])
      else $error("R6 underrun flag dropped");
  end

  for (genvar q = 0; q < NUM_LINKS / 4; q++) begin : g_q
    a_r7_pair_odd_quiet: assert property (@(posedge clk) disable iff (rst)
      ($past(grp_mode) == 2'd1) |-> (!ser_out[4*q+1] && !ser_out[4*q+3] &&
                                     !clash[4*q+1] && !clash[4*q+3]))
      else $error("R7 odd stream active in pair mode");

    a_r8_quad_tail_quiet: assert property (@(posedge clk) disable iff (rst)
      $past(grp_mode[1]) |-> (ser_out[4*q+3 -: 3] == 3'b000 &&
                              clash[4*q+3 -: 3] == 3'b000))
      else $error("R8 non-leading stream active in quad mode");
  end
endmodule

bind tdm_tx_group tdm_tx_group_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fsync_n  (fsync_n),
  .sync_seen(sync_seen),
  .grp_mode (grp_mode),
  .byte_req (byte_req),
  .underrun (underrun),
  .ser_out  (ser_out),
  .clash    (clash)
);

// File: tb/tdm_tx_group_tb_top.sv
module tdm_tx_group_tb_top;
  localparam int NL = 4;
  localparam int NS = 32;
  localparam int BW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fsync_n = 1'b1;
  logic [1:0]        grp_mode = 2'd0;
  logic [NL*NS-1:0]  slot_map = '0;
  logic [NL*BW-1:0]  din = '0;
  logic [NL-1:0]     din_vld = '0;
  logic [NL-1:0]     byte_req, underrun, ser_out, clash;

  int          n_chk = 0;
  int          n_err = 0;
  int          fc = 0;
  int          early_at = -1;
  bit          sync_on = 1'b0;
  bit          preload = 1'b0;
  logic [NL-1:0] starve = '0;
  logic [7:0]  tag = 8'h11;

  typedef struct {
    string      rq;
    int         stream;
    int         slot;
    logic [7:0] val;
  } exp_t;
  exp_t exp_q[$];
  event mon_start, mon_done;

  tdm_tx_group dut_i (
    .clk(clk), .rst(rst), .fsync_n(fsync_n), .grp_mode(grp_mode),
    .slot_map(slot_map), .din(din), .din_vld(din_vld),
    .byte_req(byte_req), .underrun(underrun), .ser_out(ser_out), .clash(clash)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(int i, int s, logic [7:0] t);
    return 8'(s * 7 + i * 61) ^ t;
  endfunction

  function automatic logic [7:0] exp_link(int i, int s);
    if (!slot_map[i*NS+s]) return 8'h00;
    return starve[i] ? 8'hFF : pat(i, s, tag);
  endfunction

  function automatic logic [7:0] exp_stream(int k, int s);
    case (grp_mode)
      2'd0:    return exp_link(k, s);
      2'd1:    return (k % 2 == 0) ? (exp_link(k, s) | exp_link(k+1, s)) : 8'h00;
      default: return (k % 4 == 0) ? (exp_link(k, s) | exp_link(k+1, s) |
                                      exp_link(k+2, s) | exp_link(k+3, s)) : 8'h00;
    endcase
  endfunction

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // bench frame position: 0 right after the edge that samples sync low
  always @(posedge clk) begin
    if (rst)           fc <= 0;
    else if (!fsync_n) fc <= 0;
    else               fc <= (fc + 1) % 512;
  end

  always @(negedge clk) begin
    if (!fsync_n) fsync_n <= 1'b1;
    else if (sync_on && (fc == 511 || fc == early_at)) fsync_n <= 1'b0;
  end

  // byte source: answers each request one cycle later
  always @(negedge clk) begin
    din_vld <= '0;
    for (int i = 0; i < NL; i++) begin
      if (preload) begin
        din[i*BW +: BW] <= pat(i, 0, tag);
        din_vld[i]      <= 1'b1;
      end else if (byte_req[i] && !starve[i]) begin
        din[i*BW +: BW] <= pat(i, ((fc + 2) / 16) % NS, tag);
        din_vld[i]      <= 1'b1;
      end
    end
  end

  // monitor: rebuilds bytes from the streams and scores them
  initial begin
    logic [7:0] got [NL];
    exp_t e;
    forever begin
      @(mon_start);
      do @(negedge clk); while (fc != 3);
      for (int s = 0; s < NS; s++) begin
        for (int k = 0; k < NL; k++) got[k] = 8'h00;
        for (int b = 0; b < 8; b++) begin
          for (int k = 0; k < NL; k++) got[k] = {got[k][6:0], ser_out[k]};
          if (!(s == NS-1 && b == 7)) repeat (2) @(negedge clk);
        end
        for (int k = 0; k < NL; k++) begin
          e = exp_q.pop_front();
          check(got[e.stream] == e.val, e.rq,
                $sformatf("stream %0d slot %0d", e.stream, e.slot),
                32'(got[e.stream]), 32'(e.val));
        end
      end
      -> mon_done;
    end
  end

  task automatic wait_fc(int v);
    do @(negedge clk); while (fc != v);
  endtask

  task automatic check_frame(string rq);
    wait_fc(505);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NL; k++)
        exp_q.push_back('{rq, k, s, exp_stream(k, s)});
    -> mon_start;
    @(mon_done);
  endtask

  task automatic apply(int mode, logic [31:0] m0, logic [31:0] m1, logic [31:0] m2,
                       logic [31:0] m3, logic [NL-1:0] st, logic [7:0] t);
    wait_fc(505);
    grp_mode = 2'(mode);
    slot_map = {m3, m2, m1, m0};
    starve   = st;
    tag      = t;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(ser_out == '0 && byte_req == '0 && underrun == '0 && clash == '0,
          "R1", "reset outputs", {ser_out, byte_req, underrun, clash}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    grp_mode = 2'd0;
    slot_map = {32'hFFFF_0001, 32'h0F0F_0F0F, 32'hA5A5_A5A5, 32'hFFFF_FFFF};
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check(ser_out == '0 && byte_req == '0, "R2", "before first sync",
            {ser_out, byte_req}, 32'h0);
    end
    @(posedge clk); #1 preload = 1'b1;
    @(posedge clk); #1 preload = 1'b0;
    sync_on = 1'b1;
    repeat (3) @(negedge clk);
    check(clash == 4'b0000, "R9", "single mode overlap", 32'(clash), 32'h0);
    check_frame("R3 R4 R8");
    check(underrun == 4'b0000, "R5", "preloaded and answered bytes", 32'(underrun), 32'h0);

    apply(1, 32'h0000_FFFF, 32'hFFFF_0000, 32'h5555_5555, 32'hAAAA_AAAA, 4'b0000, 8'h3C);
    repeat (3) @(negedge clk);
    check(clash == 4'b0000, "R9", "pair mode disjoint", 32'(clash), 32'h0);
    check_frame("R7");

    apply(2, 32'h0000_00FF, 32'h0000_FF00, 32'h00FF_0000, 32'hFF00_0000, 4'b0100, 8'h5A);
    repeat (3) @(negedge clk);
    check(clash == 4'b0000, "R9", "quad mode disjoint", 32'(clash), 32'h0);
    check_frame("R6 R8");
    check(underrun == 4'b0100, "R6", "starved link flag", 32'(underrun), 32'h4);

    apply(3, 32'h0000_0F01, 32'h00F0_0000, 32'h0000_0000, 32'h8000_0001, 4'b0000, 8'hC3);
    repeat (3) @(negedge clk);
    check(clash == 4'b0001, "R9", "quad overlap", 32'(clash), 32'h1);
    check_frame("R8");

    apply(1, 32'h0000_00F0, 32'h0000_000F, 32'h0000_FF00, 32'h0000_0300, 4'b0000, 8'h77);
    repeat (3) @(negedge clk);
    check(clash == 4'b0100, "R9", "upper pair overlap", 32'(clash), 32'h4);
    check_frame("R7");

    apply(0, 32'hFFFF_FFFE, 32'h1234_5678, 32'h8000_0000, 32'h0000_0002, 4'b0000, 8'h0F);
    wait_fc(100);
    early_at = 200;
    do @(negedge clk); while (fsync_n);
    early_at = -1;
    check_frame("R10");
    check(underrun == 4'b0100, "R6", "flag still held", 32'(underrun), 32'h4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule